// File: doc/BRIEF.md
# Static LCD Driver for a 3½-Digit Reading

This block turns a finished conversion result into the drive signals of a direct-drive (static) liquid crystal panel. It takes three BCD digits (ones, tens, hundreds), a single bit for the leading half digit, a sign bit and a lamp-test request. From these it produces a backplane square wave and one line per segment. The panel must never see a DC voltage. For that reason every segment line is a copy of the backplane: the copy stays in phase when the segment is dark and is inverted when the segment is lit.

The backplane comes from the oscillator clock. It is divided by a prescaler and then by the backplane ratio, so with the default settings it runs at 1/800 of the clock. All segment lines are loaded on the same clock edge that toggles the backplane, so the two kinds of line always change together. The leading half digit has one line that lights its b and c segments at once, so it can only show "1". Lamp test lights the whole panel, showing "-1888", and holds every segment line at a steady high level for as long as the request lasts.

Top module: `lcd_static_drv`

## Requirements
- R1: The backplane `bp` toggles every HALF = PRESC*BP_DIV/2 clock cycles. With the defaults (PRESC=4, BP_DIV=200) it toggles every 400 cycles, giving a full period of 800 oscillator cycles.
- R2: While `rst_n` is low, `bp` and every segment output are 0. After release, `bp` first rises on the HALF-th rising clock edge.
- R3: When lamp test is not in effect, a dark segment output equals `bp` and a lit segment output equals the inverse of `bp`.
- R4: Inputs are sampled only on the clock edge where `bp` toggles. A segment output never changes in a cycle where `bp` does not change.
- R5: Each digit bus uses bit 0 = a through bit 6 = g. Codes 0..9 give the standard patterns 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F.
- R6: Digit codes 10 to 15 light no segment of that digit.
- R7: `seg_lead_bc` is lit when `lead_one` is 1 and dark when it is 0.
- R8: `seg_minus` is lit when `neg` is 1 (negative reading) and dark when it is 0.
- R9: When `lamp_test` is 1 at a backplane edge, every segment output is driven to a constant 1 from that edge on, whatever the digit, sign and lead inputs are. The backplane keeps toggling during this time.
- R10: When `lamp_test` is 0 at a backplane edge, the segment outputs go back to the AC drive of R3 from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| digit_ones | input | 4 | BCD units digit |
| digit_tens | input | 4 | BCD tens digit |
| digit_hund | input | 4 | BCD hundreds digit |
| lead_one | input | 1 | Leading half digit shows "1" |
| neg | input | 1 | Reading is negative |
| lamp_test | input | 1 | Light all segments with steady drive |
| bp | output | 1 | Backplane square wave |
| seg_ones | output | 7 | Units segments, bit 0 = a .. bit 6 = g |
| seg_tens | output | 7 | Tens segments |
| seg_hund | output | 7 | Hundreds segments |
| seg_lead_bc | output | 1 | Combined b/c segment of the half digit |
| seg_minus | output | 1 | Minus-sign segment |

## Verification
The lamp-test override and the ordinary phase inversion both act at the same backplane edge. Each edge must pick exactly one of the two: a steady all-high pattern, or the backplane XORed with the decoded digits. To provoke this, the bench switches lamp test on and off between edges while it also changes the digits, sign and lead bit at random. After each edge it checks the whole segment vector against a model built only from the inputs latched at that edge. It also checks that the segment lines did not move at any point between two backplane toggles.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  localparam int SEGS_PER_DIGIT = 7;
  localparam int FULL_DIGITS    = 3;
  localparam int SEG_TOTAL      = FULL_DIGITS * SEGS_PER_DIGIT + 2;

  typedef logic [SEGS_PER_DIGIT-1:0] seg7_t;

  // bit 0 = a, 1 = b, 2 = c, 3 = d, 4 = e, 5 = f, 6 = g
  function automatic seg7_t bcd_to_seg7(input logic [3:0] code);
    seg7_t s;
    case (code)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

  // AC drive: lit segments invert the backplane, dark ones follow it;
  // lamp mode forces a steady level equal to the lit state.
  function automatic logic [SEG_TOTAL-1:0] drive_level(
      input logic [SEG_TOTAL-1:0] lit, input logic bp_lvl, input logic lamp);
    return lamp ? lit : (lit ^ {SEG_TOTAL{bp_lvl}});
  endfunction
endpackage

// File: rtl/lcd_bp_div.sv
module lcd_bp_div #(
  parameter int HALF = 400
) (
  input  logic clk,
  input  logic rst_n,
  output logic bp,
  output logic bp_edge,
  output logic bp_next
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  assign bp_edge = (cnt == LAST);
  assign bp_next = ~bp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      bp  <= 1'b0;
    end else if (bp_edge) begin
      cnt <= '0;
      bp  <= bp_next;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_seg_map.sv
module lcd_seg_map
  import lcd_pkg::*;
#(
  parameter int NDIG = FULL_DIGITS
) (
  input  logic [NDIG*4-1:0]                digits,
  input  logic                             lead_one,
  input  logic                             neg,
  input  logic                             lamp,
  output logic [NDIG*SEGS_PER_DIGIT+1:0]   lit
);
  localparam int DW = NDIG * SEGS_PER_DIGIT;

  logic [DW-1:0] decoded;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    assign decoded[g*SEGS_PER_DIGIT +: SEGS_PER_DIGIT] = bcd_to_seg7(digits[g*4 +: 4]);
  end

  always_comb begin
    if (lamp) lit = '1;
    else      lit = {neg, lead_one, decoded};
  end
endmodule

// File: rtl/lcd_seg_phase.sv
module lcd_seg_phase
  import lcd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 bp_next,
  input  logic                 lamp,
  input  logic [SEG_TOTAL-1:0] lit,
  output logic [SEG_TOTAL-1:0] seg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    seg_q <= '0;
    else if (load) seg_q <= drive_level(lit, bp_next, lamp);
  end
endmodule

// File: rtl/lcd_static_drv.sv
module lcd_static_drv
  import lcd_pkg::*;
#(
  parameter int PRESC  = 4,
  parameter int BP_DIV = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] digit_ones,
  input  logic [3:0] digit_tens,
  input  logic [3:0] digit_hund,
  input  logic       lead_one,
  input  logic       neg,
  input  logic       lamp_test,
  output logic       bp,
  output logic [6:0] seg_ones,
  output logic [6:0] seg_tens,
  output logic [6:0] seg_hund,
  output logic       seg_lead_bc,
  output logic       seg_minus
);
  localparam int HALF = (PRESC * BP_DIV) / 2;

  logic                 bp_edge;
  logic                 bp_next;
  logic [SEG_TOTAL-1:0] lit;
  logic [SEG_TOTAL-1:0] seg_q;

  lcd_bp_div #(.HALF(HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .bp(bp), .bp_edge(bp_edge), .bp_next(bp_next)
  );

  lcd_seg_map #(.NDIG(FULL_DIGITS)) u_map (
    .digits({digit_hund, digit_tens, digit_ones}),
    .lead_one(lead_one), .neg(neg), .lamp(lamp_test), .lit(lit)
  );

  lcd_seg_phase u_phase (
    .clk(clk), .rst_n(rst_n), .load(bp_edge), .bp_next(bp_next),
    .lamp(lamp_test), .lit(lit), .seg_q(seg_q)
  );

  assign seg_ones    = seg_q[6:0];
  assign seg_tens    = seg_q[13:7];
  assign seg_hund    = seg_q[20:14];
  assign seg_lead_bc = seg_q[21];
  assign seg_minus   = seg_q[22];
endmodule

// File: rtl/lcd_static_drv_chk.sv
module lcd_static_drv_chk #(
  parameter int HALF = 400
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bp,
  input logic        bp_edge,
  input logic        lamp_test,
  input logic        neg,
  input logic        lead_one,
  input logic [22:0] seg_all
);
  localparam int HW = $clog2(HALF + 1) + 1;
  logic [HW-1:0] hold;
  logic          bp_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold <= '0;
    else if (bp_chg) hold <= '0;
    else             hold <= hold + 1'b1;
  end
  assign bp_chg = (bp_edge == 1'b1);

  p_half_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bp != $past(bp)) |-> ($past(hold) == HW'(HALF - 1)));

  p_hold_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hold < HW'(HALF));

  p_seg_only_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bp == $past(bp)) |-> $stable(seg_all));

  p_lamp_all_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lamp_test) && (bp != $past(bp))) |-> (&seg_all));

  p_minus_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(lamp_test) && (bp != $past(bp))) |-> (seg_all[22] == (bp ^ $past(neg))));

  p_lead_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(lamp_test) && (bp != $past(bp))) |-> (seg_all[21] == (bp ^ $past(lead_one))));
endmodule

bind lcd_static_drv lcd_static_drv_chk #(.HALF(HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .bp(bp), .bp_edge(bp_edge),
  .lamp_test(lamp_test), .neg(neg), .lead_one(lead_one), .seg_all(seg_q)
);

// File: tb/test_lcd_static_drv.sv
module test_lcd_static_drv;
  localparam int PRESC  = 2;
  localparam int BP_DIV = 10;
  localparam int HALF   = PRESC * BP_DIV / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] d_one = '0, d_ten = '0, d_hun = '0;
  logic       lead = 1'b0, neg = 1'b0, lamp = 1'b0;
  logic       bp;
  logic [6:0] s_one, s_ten, s_hun;
  logic       s_lead, s_minus;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  lcd_static_drv #(.PRESC(PRESC), .BP_DIV(BP_DIV)) i_lcd_static_drv (
    .clk(clk), .rst_n(rst_n), .digit_ones(d_one), .digit_tens(d_ten),
    .digit_hund(d_hun), .lead_one(lead), .neg(neg), .lamp_test(lamp),
    .bp(bp), .seg_ones(s_one), .seg_tens(s_ten), .seg_hund(s_hun),
    .seg_lead_bc(s_lead), .seg_minus(s_minus)
  );

  // segment membership per digit, bit 0 = a .. bit 6 = g
  function automatic logic [6:0] ref_seg(input logic [3:0] d);
    logic [6:0] s = '0;
    if (d <= 4'd9) begin
      s[0] = !(d == 1 || d == 4);
      s[1] = !(d == 5 || d == 6);
      s[2] = (d != 2);
      s[3] = !(d == 1 || d == 4 || d == 7);
      s[4] = (d == 0 || d == 2 || d == 6 || d == 8);
      s[5] = !(d == 1 || d == 2 || d == 3 || d == 7);
      s[6] = !(d == 0 || d == 1 || d == 7);
    end
    return s;
  endfunction

  function automatic logic [22:0] ref_out(input logic b);
    logic [22:0] on;
    if (lamp) return '1;
    on = {neg, lead, ref_seg(d_hun), ref_seg(d_ten), ref_seg(d_one)};
    return b ? ~on : on;
  endfunction

  function automatic logic [22:0] got();
    return {s_minus, s_lead, s_hun, s_ten, s_one};
  endfunction

  task automatic check(input string tag, input logic [22:0] act, input logic [22:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // wait for the next backplane toggle; check its spacing and seg stability
  task automatic step(input string tag);
    logic        prev_bp  = bp;
    logic [22:0] prev_seg = got();
    int          n = 0;
    bit          moved = 1'b0;
    do begin
      @(negedge clk);
      n++;
      if (bp === prev_bp && got() !== prev_seg) moved = 1'b1;
      if (n > 4 * HALF) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: no backplane toggle after %0d cycles, expected %0d", n, HALF);
        finish_run();
      end
    end while (bp === prev_bp);
    check("R1 half period", 23'(n), 23'(HALF));
    check("R4 segments held between edges", {22'd0, moved}, 23'd0);
    check(tag, got(), ref_out(bp));
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: global timeout, actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1CD7));
    repeat (3) @(negedge clk);
    check("R2 reset bp", {22'd0, bp}, 23'd0);
    check("R2 reset segments", got(), 23'd0);
    d_one = 4'd1; d_ten = 4'd2; d_hun = 4'd3;
    rst_n = 1'b1;
    step("R2 first edge");
    // R5 / R6: every code in every digit position
    for (int c = 0; c < 16; c++) begin
      d_one = 4'(c); d_ten = 4'(15 - c); d_hun = 4'((c + 5) % 16);
      step(c < 10 ? "R5 decode" : "R6 blank code");
    end
    d_one = 4'd7; d_ten = 4'd0; d_hun = 4'd4;
    lead = 1'b1; step("R7 lead on");
    lead = 1'b0; step("R7 lead off");
    neg = 1'b1;  step("R8 minus on");
    neg = 1'b0;  step("R8 minus off");
    neg = 1'b1; lead = 1'b1; step("R3 both on");
    step("R3 opposite phase");
    // R9: lamp holds steady high across two edges of either bp level
    lamp = 1'b1; d_one = 4'd12; neg = 1'b0; step("R9 lamp on");
    d_ten = 4'd9; lead = 1'b0; step("R9 lamp held");
    lamp = 1'b0; step("R10 lamp released");
    // R3: random mix, lamp sometimes
    for (int i = 0; i < 80; i++) begin
      d_one = 4'($urandom_range(0, 15));
      d_ten = 4'($urandom_range(0, 15));
      d_hun = 4'($urandom_range(0, 15));
      lead  = 1'($urandom_range(0, 1));
      neg   = 1'($urandom_range(0, 1));
      lamp  = ($urandom_range(0, 7) == 0);
      step(lamp ? "R9 random lamp" : "R3 random drive");
    end
    finish_run();
  end
endmodule